// File: doc/BRIEF.md
# Mode-Configurable Interleaved TCM Router

This block sits between one processor core and its tightly-coupled memory. It takes word requests from two sources, the core itself and a system-side port, and steers each one to one of six physical memory arrays. The arrays form an A bank and a B region. The B region is made of two sub-banks that alternate every doubleword. Each of the three groups has a lower half, which belongs to this core, and an upper half, which belongs to the partner core.

A static `mode` input picks the address map. In split mode only the lower halves are reachable. Anything beyond them is answered with a decode error. In combined mode this core owns both halves of every group, so every bank doubles in size.

Every stored word is a 39-bit SECDED codeword. Check bits are added on write and checked on read. A single-bit error is corrected and reported with a pulse. A double-bit error is reported with a different pulse, and the data is returned uncorrected. After reset every word holds the encoded value of `init_word`. The system port can XOR a mask into the codeword it writes, so that test code can plant errors on purpose.

Top module: `tcm_router`

## Requirements
- R1: Addresses are word addresses. In split mode (`mode`=0), words [0, A_WORDS) map to the A bank and words [A_WORDS, A_WORDS+2*B_WORDS) map to the B region. Any other address completes with `*_decerr`=1.
- R2: In combined mode (`mode`=1), the A bank spans [0, 2*A_WORDS) and the B region spans [2*A_WORDS, 2*A_WORDS+4*B_WORDS). Each group's upper half is a separate array from its lower half, so the two ports can reach both halves in the same cycle. Addresses at or above the end of the B region give a decode error. In split mode the upper-half arrays are never enabled.
- R3: Inside the B region, bit 1 of the word offset selects the sub-bank: 0 selects B0 and 1 selects B1. Consecutive doublewords therefore alternate between the two sub-banks, and both words of one doubleword sit in the same sub-bank.
- R4: Each accepted request produces `*_done` exactly one cycle later. For a read, `*_rdata` carries the data in that cycle. For a write, `*_rdata` is 0.
- R5: When both ports address the same physical array in the same cycle, the core is served. `sys_gnt` is 0 in that cycle and the system request is not executed. When the two ports address different arrays, both are served. The core port is never stalled.
- R6: Codeword layout: bit 0 is overall parity. Bits 1, 2, 4, 8, 16 and 32 are Hamming check bits. Data bits 0..31 fill the remaining positions 3, 5, 6, 7, 9, ... 38 in ascending order. A system write stores the codeword XOR `sys_wflip`. A core write always stores a clean codeword.
- R7: A read of a word whose stored codeword differs in exactly one bit returns the original data and pulses `*_ecc_corr` for one cycle, together with `*_done`.
- R8: A read of a word whose stored codeword differs in exactly two bits pulses `*_ecc_uncorr` and returns the uncorrected data field. The two ECC pulses never occur together.
- R9: During reset all outputs are 0 except `sys_gnt`, which is 1. After reset every word reads back as `init_word` with no ECC pulse.
- R10: A decode-error response has `*_rdata`=0 and raises no ECC pulse. A write to an unmapped address changes no stored word, and it never stalls the other port.
- R11: Switching `mode` leaves the contents in place. Combined-mode A words below A_WORDS, and combined-mode B offsets below 2*B_WORDS, reach the same storage as the split-mode address with the same bank offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 1 | 0 = split map, 1 = combined map |
| init_word | input | 32 | Value loaded into every word during reset |
| core_req | input | 1 | Core request |
| core_we | input | 1 | Core write (1) or read (0) |
| core_addr | input | WAW | Core word address |
| core_wdata | input | 32 | Core write data |
| core_done | output | 1 | Core response valid |
| core_rdata | output | 32 | Core read data |
| core_decerr | output | 1 | Core response is a decode error |
| core_ecc_corr | output | 1 | Core read had a corrected single-bit error |
| core_ecc_uncorr | output | 1 | Core read had a double-bit error |
| sys_req | input | 1 | System request |
| sys_we | input | 1 | System write (1) or read (0) |
| sys_addr | input | WAW | System word address |
| sys_wdata | input | 32 | System write data |
| sys_wflip | input | 39 | Mask XORed into the stored codeword on system writes |
| sys_gnt | output | 1 | System request accepted in this cycle |
| sys_done | output | 1 | System response valid |
| sys_rdata | output | 32 | System read data |
| sys_decerr | output | 1 | System response is a decode error |
| sys_ecc_corr | output | 1 | System read had a corrected single-bit error |
| sys_ecc_uncorr | output | 1 | System read had a double-bit error |

## Verification
The cycle-level rules are checked by assertions on every cycle:
- a request completes one cycle later, and a stalled system request never completes;
- the two ports never share an array;
- the upper halves stay idle in split mode;
- the ECC pulses are exclusive and appear only with a response;
- decode-error responses are clean.

Some behaviour can only be shown by the bench's scenarios:
- whether data lands in the right word and survives a mode change;
- which addresses collide under doubleword interleaving;
- whether planted one- and two-bit errors are corrected or flagged with the right data.

// File: rtl/tcmr_pkg.sv
package tcmr_pkg;

  localparam int DW    = 32;
  localparam int PB    = 6;
  localparam int CW    = DW + PB + 1;
  localparam int NBANK = 6;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          corr;
    logic          uncorr;
  } ecc_res_t;

  // Position is a check-bit slot when it is a power of two.
  function automatic logic is_chk_pos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [CW-1:0] ecc_enc(logic [DW-1:0] d);
    logic [CW-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p < CW; p++) begin
      if (!is_chk_pos(p)) begin
        c[p] = d[k];
        k = k + 1;
      end
    end
    for (int b = 0; b < PB; b++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p < CW; p++) begin
        if (((p >> b) & 1) == 1) x = x ^ c[p];
      end
      c[1 << b] = x;
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic ecc_res_t ecc_dec(logic [CW-1:0] c);
    ecc_res_t r;
    logic [PB-1:0] syn;
    logic ov;
    logic [CW-1:0] f;
    int k;
    syn = '0;
    for (int p = 1; p < CW; p++) begin
      if (c[p]) syn = syn ^ PB'(p);
    end
    ov = ^c;
    f = c;
    r.corr = 1'b0;
    r.uncorr = 1'b0;
    if (ov) begin
      if (int'(syn) < CW) begin
        f[syn] = ~f[syn];
        r.corr = 1'b1;
      end else begin
        r.uncorr = 1'b1;
      end
    end else if (syn != '0) begin
      r.uncorr = 1'b1;
    end
    r.data = '0;
    k = 0;
    for (int p = 1; p < CW; p++) begin
      if (!is_chk_pos(p)) begin
        r.data[k] = f[p];
        k = k + 1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/tcmr_decode.sv
module tcmr_decode #(
  parameter int A_WORDS = 64,
  parameter int B_WORDS = 32,
  parameter int WAW     = 9,
  parameter int IW      = 6
) (
  input  logic           mode,
  input  logic [WAW-1:0] wa,
  output logic           hit,
  output logic [2:0]     bank,
  output logic [IW-1:0]  idx
);

  // Returns {hit, group[1:0], upper, index}; bank id = group*2 + upper.
  function automatic logic [IW+3:0] map_word(logic m, logic [WAW-1:0] a);
    int w, alim, blim, off, wi, grp;
    logic hi, ok;
    w    = int'(a);
    alim = m ? 2 * A_WORDS : A_WORDS;
    blim = alim + (m ? 4 * B_WORDS : 2 * B_WORDS);
    grp  = 0;
    wi   = 0;
    hi   = 1'b0;
    ok   = 1'b1;
    if (w < alim) begin
      hi = (w >= A_WORDS);
      wi = hi ? w - A_WORDS : w;
    end else if (w < blim) begin
      off = w - alim;
      grp = 1 + ((off >> 1) & 1);
      wi  = ((off >> 2) << 1) | (off & 1);
      hi  = (wi >= B_WORDS);
      if (hi) wi = wi - B_WORDS;
    end else begin
      ok = 1'b0;
    end
    return {ok, 2'(grp), hi, IW'(wi)};
  endfunction

  always_comb begin
    {hit, bank, idx} = map_word(mode, wa);
  end

endmodule

// File: rtl/tcmr_arb.sv
module tcmr_arb #(
  parameter int NB = 6
) (
  input  logic          c_req,
  input  logic          c_hit,
  input  logic [2:0]    c_bank,
  input  logic          s_req,
  input  logic          s_hit,
  input  logic [2:0]    s_bank,
  output logic          conflict,
  output logic          s_gnt,
  output logic [NB-1:0] c_sel,
  output logic [NB-1:0] s_sel
);

  logic c_use, s_use;

  assign c_use    = c_req & c_hit;
  assign s_use    = s_req & s_hit;
  assign conflict = c_use & s_use & (c_bank == s_bank);
  assign s_gnt    = ~conflict;

  for (genvar g = 0; g < NB; g++) begin : g_sel
    assign c_sel[g] = c_use & (c_bank == 3'(g));
    assign s_sel[g] = s_use & ~conflict & (s_bank == 3'(g));
  end

endmodule

// File: rtl/tcmr_bank.sv
module tcmr_bank #(
  parameter int DEPTH = 64,
  parameter int IW    = 6,
  parameter int CW    = 39
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] init_cw,
  input  logic          en,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [CW-1:0] wcw,
  output logic [CW-1:0] rcw
);

  localparam int LW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] mem [DEPTH];
  logic          in_range;

  assign in_range = en && (int'(idx) < DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_cw;
      rcw <= init_cw;
    end else if (in_range) begin
      if (we) mem[idx[LW-1:0]] <= wcw;
      else    rcw <= mem[idx[LW-1:0]];
    end
  end

endmodule

// File: rtl/tcmr_resp.sv
module tcmr_resp
  import tcmr_pkg::*;
#(
  parameter int NB = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc,
  input  logic                   we,
  input  logic                   hit,
  input  logic [2:0]             bank,
  input  logic [NB-1:0][CW-1:0]  rcw_all,
  output logic                   done,
  output logic [DW-1:0]          rdata,
  output logic                   decerr,
  output logic                   corr,
  output logic                   uncorr
);

  logic          v_q, rd_q, hit_q;
  logic [2:0]    bank_q;
  logic [CW-1:0] cw_sel;
  ecc_res_t      res;
  logic          rd_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      rd_q   <= 1'b0;
      hit_q  <= 1'b0;
      bank_q <= '0;
    end else begin
      v_q    <= acc;
      rd_q   <= acc & ~we;
      hit_q  <= hit;
      bank_q <= bank;
    end
  end

  assign cw_sel = rcw_all[bank_q];
  assign res    = ecc_dec(cw_sel);
  assign rd_ok  = v_q & rd_q & hit_q;

  assign done   = v_q;
  assign decerr = v_q & ~hit_q;
  assign rdata  = rd_ok ? res.data : '0;
  assign corr   = rd_ok & res.corr;
  assign uncorr = rd_ok & res.uncorr;

endmodule

// File: rtl/tcm_router.sv
module tcm_router
  import tcmr_pkg::*;
#(
  parameter int A_WORDS = 64,
  parameter int B_WORDS = 32,
  parameter int WAW     = $clog2(2 * (A_WORDS + 2 * B_WORDS)) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode,
  input  logic [31:0]    init_word,
  input  logic           core_req,
  input  logic           core_we,
  input  logic [WAW-1:0] core_addr,
  input  logic [31:0]    core_wdata,
  output logic           core_done,
  output logic [31:0]    core_rdata,
  output logic           core_decerr,
  output logic           core_ecc_corr,
  output logic           core_ecc_uncorr,
  input  logic           sys_req,
  input  logic           sys_we,
  input  logic [WAW-1:0] sys_addr,
  input  logic [31:0]    sys_wdata,
  input  logic [38:0]    sys_wflip,
  output logic           sys_gnt,
  output logic           sys_done,
  output logic [31:0]    sys_rdata,
  output logic           sys_decerr,
  output logic           sys_ecc_corr,
  output logic           sys_ecc_uncorr
);

  localparam int IW = $clog2((A_WORDS > B_WORDS) ? A_WORDS : B_WORDS);

  // Decoded requests
  logic          c_hit, s_hit;
  logic [2:0]    c_bank, s_bank;
  logic [IW-1:0] c_idx, s_idx;

  // Arbitration events, brought out for the checker
  logic             arb_conflict;
  logic [NBANK-1:0] arb_c_sel, arb_s_sel;

  // Encoded write and init codewords
  logic [CW-1:0] c_cw, s_cw, init_cw;
  logic [NBANK-1:0][CW-1:0] bank_rcw;

  assign c_cw    = ecc_enc(core_wdata);
  assign s_cw    = ecc_enc(sys_wdata) ^ sys_wflip;
  assign init_cw = ecc_enc(init_word);

  tcmr_decode #(.A_WORDS(A_WORDS), .B_WORDS(B_WORDS), .WAW(WAW), .IW(IW)) u_dec_core (
    .mode(mode), .wa(core_addr), .hit(c_hit), .bank(c_bank), .idx(c_idx)
  );

  tcmr_decode #(.A_WORDS(A_WORDS), .B_WORDS(B_WORDS), .WAW(WAW), .IW(IW)) u_dec_sys (
    .mode(mode), .wa(sys_addr), .hit(s_hit), .bank(s_bank), .idx(s_idx)
  );

  tcmr_arb #(.NB(NBANK)) u_arb (
    .c_req(core_req), .c_hit(c_hit), .c_bank(c_bank),
    .s_req(sys_req), .s_hit(s_hit), .s_bank(s_bank),
    .conflict(arb_conflict), .s_gnt(sys_gnt),
    .c_sel(arb_c_sel), .s_sel(arb_s_sel)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam int DEPTH = (g < 2) ? A_WORDS : B_WORDS;
    logic          b_en, b_we;
    logic [IW-1:0] b_idx;
    logic [CW-1:0] b_wcw;

    assign b_en  = arb_c_sel[g] | arb_s_sel[g];
    assign b_we  = arb_c_sel[g] ? core_we : sys_we;
    assign b_idx = arb_c_sel[g] ? c_idx   : s_idx;
    assign b_wcw = arb_c_sel[g] ? c_cw    : s_cw;

    tcmr_bank #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_bank (
      .clk(clk), .rst_n(rst_n), .init_cw(init_cw),
      .en(b_en), .we(b_we), .idx(b_idx), .wcw(b_wcw),
      .rcw(bank_rcw[g])
    );
  end

  tcmr_resp #(.NB(NBANK)) u_rsp_core (
    .clk(clk), .rst_n(rst_n), .acc(core_req), .we(core_we),
    .hit(c_hit), .bank(c_bank), .rcw_all(bank_rcw),
    .done(core_done), .rdata(core_rdata), .decerr(core_decerr),
    .corr(core_ecc_corr), .uncorr(core_ecc_uncorr)
  );

  tcmr_resp #(.NB(NBANK)) u_rsp_sys (
    .clk(clk), .rst_n(rst_n), .acc(sys_req & sys_gnt), .we(sys_we),
    .hit(s_hit), .bank(s_bank), .rcw_all(bank_rcw),
    .done(sys_done), .rdata(sys_rdata), .decerr(sys_decerr),
    .corr(sys_ecc_corr), .uncorr(sys_ecc_uncorr)
  );

endmodule

// File: rtl/tcm_router_check.sv
module tcm_router_check #(
  parameter int NB = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode,
  input logic          core_req,
  input logic          core_done,
  input logic [31:0]   core_rdata,
  input logic          core_decerr,
  input logic          core_ecc_corr,
  input logic          core_ecc_uncorr,
  input logic          sys_req,
  input logic          sys_gnt,
  input logic          sys_done,
  input logic [31:0]   sys_rdata,
  input logic          sys_decerr,
  input logic          sys_ecc_corr,
  input logic          sys_ecc_uncorr,
  input logic [NB-1:0] arb_c_sel,
  input logic [NB-1:0] arb_s_sel
);

  // Upper-half arrays are the odd bank ids.
  localparam logic [NB-1:0] UPPER = NB'({(NB / 2){2'b10}});

  a_r4_core_done: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |=> core_done) else $error("R4 core response missing");

  a_r4_sys_done: assert property (@(posedge clk) disable iff (!rst_n)
    sys_req && sys_gnt |=> sys_done) else $error("R4 sys response missing");

  a_r5_stall_silent: assert property (@(posedge clk) disable iff (!rst_n)
    sys_req && !sys_gnt |=> !sys_done) else $error("R5 stalled sys request completed");

  a_r5_no_shared_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_c_sel & arb_s_sel) == '0) else $error("R5 both ports on one array");

  a_r1_one_bank_core: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_c_sel)) else $error("R1 core selects several arrays");

  a_r1_one_bank_sys: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_s_sel)) else $error("R1 sys selects several arrays");

  a_r2_split_upper_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> ((arb_c_sel | arb_s_sel) & UPPER) == '0) else $error("R2 upper half used in split mode");

  a_r8_core_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_ecc_corr && core_ecc_uncorr)) else $error("R8 core pulses together");

  a_r8_sys_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_ecc_corr && sys_ecc_uncorr)) else $error("R8 sys pulses together");

  a_r7_core_pulse_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ecc_corr || core_ecc_uncorr) |-> core_done) else $error("R7 core pulse without response");

  a_r7_sys_pulse_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_ecc_corr || sys_ecc_uncorr) |-> sys_done) else $error("R7 sys pulse without response");

  a_r10_core_decerr_clean: assert property (@(posedge clk) disable iff (!rst_n)
    core_decerr |-> core_rdata == '0 && !core_ecc_corr && !core_ecc_uncorr)
    else $error("R10 core decode error not clean");

  a_r10_sys_decerr_clean: assert property (@(posedge clk) disable iff (!rst_n)
    sys_decerr |-> sys_rdata == '0 && !sys_ecc_corr && !sys_ecc_uncorr)
    else $error("R10 sys decode error not clean");

endmodule

bind tcm_router tcm_router_check #(.NB(tcmr_pkg::NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode),
  .core_req(core_req), .core_done(core_done), .core_rdata(core_rdata),
  .core_decerr(core_decerr), .core_ecc_corr(core_ecc_corr), .core_ecc_uncorr(core_ecc_uncorr),
  .sys_req(sys_req), .sys_gnt(sys_gnt), .sys_done(sys_done), .sys_rdata(sys_rdata),
  .sys_decerr(sys_decerr), .sys_ecc_corr(sys_ecc_corr), .sys_ecc_uncorr(sys_ecc_uncorr),
  .arb_c_sel(arb_c_sel), .arb_s_sel(arb_s_sel)
);

// File: tb/tcm_router_test.sv
module tcm_router_test;

  localparam int AWD = 64;
  localparam int BWD = 32;
  localparam int WAW = 9;
  localparam logic [31:0] INIT = 32'hA5C3_0F96;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, mode;
  logic core_req, core_we, sys_req, sys_we;
  logic [WAW-1:0] core_addr, sys_addr;
  logic [31:0] core_wdata, sys_wdata;
  logic [38:0] sys_wflip;
  logic core_done, core_decerr, core_ecc_corr, core_ecc_uncorr;
  logic sys_gnt, sys_done, sys_decerr, sys_ecc_corr, sys_ecc_uncorr;
  logic [31:0] core_rdata, sys_rdata;

  tcm_router #(.A_WORDS(AWD), .B_WORDS(BWD)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .init_word(INIT),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_done(core_done), .core_rdata(core_rdata), .core_decerr(core_decerr),
    .core_ecc_corr(core_ecc_corr), .core_ecc_uncorr(core_ecc_uncorr),
    .sys_req(sys_req), .sys_we(sys_we), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
    .sys_wflip(sys_wflip), .sys_gnt(sys_gnt), .sys_done(sys_done), .sys_rdata(sys_rdata),
    .sys_decerr(sys_decerr), .sys_ecc_corr(sys_ecc_corr), .sys_ecc_uncorr(sys_ecc_uncorr)
  );

  typedef struct {
    logic [31:0] data;
    logic derr;
    logic corr;
    logic unc;
    string tag;
  } exp_t;

  exp_t cq[$];
  exp_t sq[$];
  logic [31:0] mdata [int];
  logic [38:0] mflip [int];
  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Physical location: group*2000 + upper*1000 + index; -1 when unmapped.
  function automatic int loc(int wa, logic m);
    int asz, bsz, off, sub, w;
    asz = m ? 2 * AWD : AWD;
    bsz = m ? 4 * BWD : 2 * BWD;
    if (wa < asz) return (wa / AWD) * 1000 + wa % AWD;
    if (wa >= asz + bsz) return -1;
    off = wa - asz;
    sub = (off / 2) % 2;
    w = (off / 4) * 2 + off % 2;
    return 2000 + sub * 2000 + (w / BWD) * 1000 + w % BWD;
  endfunction

  // Data bit carried at codeword position p (p not a power of two).
  function automatic int dpos(int p);
    int n;
    n = 0;
    for (int q = 1; q <= p; q = q * 2) n++;
    return p - 1 - n;
  endfunction

  function automatic exp_t predict(int wa, logic m, bit rd, string tag);
    exp_t e;
    int key;
    logic [31:0] d;
    logic [38:0] f;
    e.data = '0; e.derr = 0; e.corr = 0; e.unc = 0; e.tag = tag;
    key = loc(wa, m);
    if (key < 0) begin
      e.derr = 1;
      return e;
    end
    if (!rd) return e;
    d = mdata.exists(key) ? mdata[key] : INIT;
    f = mflip.exists(key) ? mflip[key] : '0;
    if ($countones(f) == 1) e.corr = 1;
    else if ($countones(f) == 2) begin
      e.unc = 1;
      for (int p = 1; p < 39; p++)
        if (f[p] && ((p & (p - 1)) != 0)) d[dpos(p)] = ~d[dpos(p)];
    end
    e.data = d;
    return e;
  endfunction

  task automatic mwrite(int wa, logic m, logic [31:0] d, logic [38:0] f);
    int key;
    key = loc(wa, m);
    if (key >= 0) begin
      mdata[key] = d;
      mflip[key] = f;
    end
  endtask

  // Driver: one cycle of stimulus on both ports.
  task automatic cyc(bit cr, bit cw, int ca, logic [31:0] cd,
                     bit sr, bit sw, int sa, logic [31:0] sd, logic [38:0] sf,
                     bit eg, string tag);
    @(negedge clk);
    core_req = cr; core_we = cw; core_addr = WAW'(ca); core_wdata = cd;
    sys_req = sr; sys_we = sw; sys_addr = WAW'(sa); sys_wdata = sd; sys_wflip = sf;
    #1;
    if (sr) chk(sys_gnt === eg, tag, "sys_gnt", 64'(sys_gnt), 64'(eg));
    if (cr) begin
      cq.push_back(predict(ca, mode, !cw, tag));
      if (cw) mwrite(ca, mode, cd, '0);
    end
    if (sr && sys_gnt) begin
      sq.push_back(predict(sa, mode, !sw, tag));
      if (sw) mwrite(sa, mode, sd, sf);
    end
    @(posedge clk);
    #1;
    core_req = 0; sys_req = 0;
  endtask

  task automatic crd(int a, string tag);
    cyc(1, 0, a, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic cwr(int a, logic [31:0] d, string tag);
    cyc(1, 1, a, d, 0, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic srd(int a, string tag);
    cyc(0, 0, 0, 0, 1, 0, a, 0, 0, 1, tag);
  endtask
  task automatic swr(int a, logic [31:0] d, logic [38:0] f, string tag);
    cyc(0, 0, 0, 0, 1, 1, a, d, f, 1, tag);
  endtask

  // Monitor: pops expectations as responses appear.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (core_done) begin
        if (cq.size() == 0) chk(0, "R4", "core unexpected response", 1, 0);
        else begin
          exp_t e;
          e = cq.pop_front();
          chk({core_decerr, core_ecc_corr, core_ecc_uncorr, core_rdata} ===
              {e.derr, e.corr, e.unc, e.data}, e.tag, "core {decerr,corr,uncorr,rdata}",
              64'({core_decerr, core_ecc_corr, core_ecc_uncorr, core_rdata}),
              64'({e.derr, e.corr, e.unc, e.data}));
        end
      end
      if (sys_done) begin
        if (sq.size() == 0) chk(0, "R4", "sys unexpected response", 1, 0);
        else begin
          exp_t e;
          e = sq.pop_front();
          chk({sys_decerr, sys_ecc_corr, sys_ecc_uncorr, sys_rdata} ===
              {e.derr, e.corr, e.unc, e.data}, e.tag, "sys {decerr,corr,uncorr,rdata}",
              64'({sys_decerr, sys_ecc_corr, sys_ecc_uncorr, sys_rdata}),
              64'({e.derr, e.corr, e.unc, e.data}));
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R4", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; mode = 0;
    core_req = 0; core_we = 0; core_addr = '0; core_wdata = '0;
    sys_req = 0; sys_we = 0; sys_addr = '0; sys_wdata = '0; sys_wflip = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state at the ports
    chk({core_done, core_decerr, core_ecc_corr, core_ecc_uncorr, core_rdata} == '0,
        "R9", "core outputs in reset", 64'(core_rdata), 0);
    chk({sys_done, sys_decerr, sys_ecc_corr, sys_ecc_uncorr, sys_rdata} == '0,
        "R9", "sys outputs in reset", 64'(sys_rdata), 0);
    chk(sys_gnt == 1'b1, "R9", "sys_gnt in reset", 64'(sys_gnt), 1);
    rst_n = 1;

    // R9: untouched words read as init value on both ports
    cyc(1, 0, 0, 0, 1, 0, 70, 0, 0, 1, "R9");
    crd(127, "R9");

    // R1: split-mode writes to A and B from both ports
    cyc(1, 1, 1, 32'h1111_1111, 1, 1, 64, 32'h2222_2222, 0, 1, "R1");
    // R3: offsets 0 and 1 share B0 -> stall, then retry
    cyc(1, 1, 64, 32'h2222_0000, 1, 1, 65, 32'h3333_3333, 0, 0, "R3");
    swr(65, 32'h3333_3333, 0, "R3");
    // R3: offset 2 is B1, offset 4 is B0 -> no stall
    cyc(1, 1, 66, 32'h4444_4444, 1, 1, 68, 32'h5555_5555, 0, 1, "R3");
    // R5: offset 2 and offset 7 both B1 -> core wins
    cyc(1, 0, 66, 0, 1, 0, 71, 0, 0, 0, "R5");
    srd(71, "R5");
    // R5: A and B together are both served
    cyc(1, 0, 1, 0, 1, 0, 64, 0, 0, 1, "R5");
    // R4: readback on both ports
    crd(65, "R4");
    srd(66, "R4");
    crd(68, "R4");

    // R10: decode errors in split mode
    crd(128, "R10");
    swr(200, 32'hDEAD_BEEF, 0, "R10");
    cyc(1, 0, 0, 0, 1, 0, 130, 0, 0, 1, "R10");
    crd(0, "R10");
    srd(64, "R10");
    crd(72, "R10");

    // R6/R7: planted single-bit errors
    swr(10, 32'h1234_5678, 39'(1) << 7, "R7");
    swr(11, 32'h0F0F_F0F0, 39'(1), "R7");
    crd(10, "R7");
    srd(11, "R7");
    // R8: planted double-bit errors (data bits 0 and 1, then check bits)
    swr(12, 32'hCAFE_0000, (39'(1) << 3) | (39'(1) << 5), "R8");
    swr(13, 32'h0000_BEEF, (39'(1) << 1) | (39'(1) << 2), "R8");
    crd(12, "R8");
    srd(13, "R8");
    // R6: core write stores a clean codeword
    cwr(10, 32'h7654_3210, "R6");
    crd(10, "R6");

    // R11/R2: combined mode
    @(negedge clk);
    mode = 1;
    crd(128, "R11");
    crd(130, "R11");
    srd(1, "R11");
    cyc(1, 1, 100, 32'hAAAA_0001, 1, 1, 36, 32'hBBBB_0002, 0, 1, "R2");
    cyc(1, 1, 5, 32'hCCCC_0003, 1, 1, 6, 32'hDDDD_0004, 0, 0, "R2");
    swr(6, 32'hDDDD_0004, 0, "R2");
    cyc(1, 1, 200, 32'hEEEE_0005, 1, 1, 136, 32'hFFFF_0006, 0, 1, "R2");
    crd(100, "R2");
    srd(36, "R2");
    crd(200, "R2");
    srd(136, "R2");
    crd(255, "R2");
    crd(256, "R2");
    crd(6, "R2");

    // R11: back to split, lower halves still hold their words
    @(negedge clk);
    mode = 0;
    crd(36, "R11");
    crd(100, "R11");

    repeat (4) @(negedge clk);
    chk(cq.size() == 0 && sq.size() == 0, "R4", "pending responses",
        64'(cq.size() + sq.size()), 0);
    finish_run();
  end

endmodule